// File: doc/BRIEF.md
# Noise-Shaped Fixed-Point DC Blocker

This block is a streaming first-order high-pass filter that strips the DC component from a signed fixed-point sample stream. The output word is as wide as the input word. Each accepted sample is combined in a wide accumulator. The accumulator holds the difference between the new input and the previous input, plus the pole coefficient times the previous output, plus the requantization error saved from the previous sample. The accumulator is then cut back to the output width by discarding its low fractional bits, and the output saturates when it falls outside the representable range. The error left over by this cut is stored and folded into the next accumulation. The noise added by requantization therefore passes through a zero at DC, and the block adds no average offset of its own.

A control input selects an alternative overflow behaviour. When it is set and a sample clips, the next accepted sample subtracts the stored error instead of adding it. This one-time subtraction drains the excess that overflow left in the error register, so a full-scale step produces a single clipped sample rather than a run of them. The cost is a small residual DC error.

Samples flow through a valid/ready stream on both sides. A sample is accepted on a clock edge where `in_valid` and `in_ready` are both high. The result is presented one clock later with `out_valid`. The block has a single output register. `in_ready` is high whenever that register is empty or is being drained in the same cycle (`out_ready` high). While `out_valid` is high and `out_ready` is low, the output holds and no new sample is taken.

Top module: `dc_blocker`

## Requirements
- R1: Synchronous active-low reset clears the previous-input, previous-output and error state to zero and deasserts `out_valid`, so the first output after reset equals the first input sample exactly.
- R2: For each accepted input x, the accumulator is A = (x - xp)*2^30 + ALPHA*yp + s*e, in units of 2^-60. Here xp and yp are the previous accepted input and output, ALPHA is the signed 2.30 pole parameter (default 1073227115, about 0.99952064), e is the stored error, and s is +1 in normal operation. The output is y = floor(A / 2^30), saturated to 32 bits.
- R3: After each accepted sample the stored error becomes e = A - y*2^30. When the sample did not clip, this lies in [0, 2^30).
- R4: Input and output are signed 2.30 words. If floor(A / 2^30) exceeds 0x7FFFFFFF, the output is 0x7FFFFFFF. If it is below 0x80000000, the output is 0x80000000. The output never wraps.
- R5: If `flip_en` is high when a sample that clips is accepted, the next accepted sample uses s = -1. Every other sample uses s = +1.
- R6: `out_valid` rises on the clock after an accepted sample. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold.
- R7: Cycles without acceptance (`in_valid` low, or the input stalled by back-pressure) leave the filter state unchanged, whatever is on `in_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| flip_en | input | 1 | Enables the one-sample error sign reversal after a clipped sample |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | 32 | Signed 2.30 input sample |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream takes the output this cycle |
| out_data | output | 32 | Signed 2.30 filtered sample |

## Verification
The bench aims at full-scale steps in both directions, with and without `flip_en`. An adder that wraps instead of saturating would show a sign flip there, and an error path with the wrong sign, or a flip that lasts more than one sample, would move every later output away from the model. A long run of a constant non-trivial input exercises residue recycling. Dropping or truncating the stored error produces a slowly growing mismatch that a short test would miss. Idle cycles with junk on the data bus, and a stall with the output held, catch state that updates without a handshake and outputs that move under back-pressure.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

  // Sign applied to the recycled requantization error.
  typedef enum logic {
    FB_ADD = 1'b0,
    FB_SUB = 1'b1
  } fb_sign_e;

endpackage

// File: rtl/dcb_accum.sv
module dcb_accum
  import dcb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 30,
  parameter int ACC_W  = 68,
  parameter logic signed [DATA_W-1:0] ALPHA = 32'sd1073227115
) (
  input  logic signed [DATA_W-1:0] x_in,
  input  logic signed [DATA_W-1:0] x_prev,
  input  logic signed [DATA_W-1:0] y_prev,
  input  logic signed [ACC_W-1:0]  err,
  input  fb_sign_e                 fb_sign,
  output logic signed [ACC_W-1:0]  acc
);

  localparam int EXT_W = ACC_W - DATA_W;

  logic signed [ACC_W-1:0] x_w, xp_w, yp_w, alpha_w;
  logic signed [ACC_W-1:0] diff_w, prod_w, fb_w;

  always_comb begin
    x_w     = {{EXT_W{x_in[DATA_W-1]}}, x_in};
    xp_w    = {{EXT_W{x_prev[DATA_W-1]}}, x_prev};
    yp_w    = {{EXT_W{y_prev[DATA_W-1]}}, y_prev};
    alpha_w = {{EXT_W{ALPHA[DATA_W-1]}}, ALPHA};
    // input difference aligned to the product's fractional weight
    diff_w  = (x_w - xp_w) <<< FRAC_W;
    prod_w  = yp_w * alpha_w;
    fb_w    = (fb_sign == FB_SUB) ? -err : err;
    acc     = diff_w + prod_w + fb_w;
  end

endmodule

// File: rtl/dcb_requant.sv
module dcb_requant #(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 30,
  parameter int ACC_W  = 68
) (
  input  logic signed [ACC_W-1:0]  acc,
  output logic signed [DATA_W-1:0] y,
  output logic signed [ACC_W-1:0]  err_new,
  output logic                     clip_hi,
  output logic                     clip_lo
);

  localparam int EXT_W = ACC_W - DATA_W;
  localparam logic signed [ACC_W-1:0] LIM_HI = {{(EXT_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] LIM_LO = {{(EXT_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
  localparam logic signed [DATA_W-1:0] Y_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] Y_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [ACC_W-1:0] q;
  logic signed [ACC_W-1:0] y_w;

  always_comb begin
    // floor division by discarding the low fractional bits
    q       = acc >>> FRAC_W;
    clip_hi = (q > LIM_HI);
    clip_lo = (q < LIM_LO);
    if (clip_hi)      y = Y_MAX;
    else if (clip_lo) y = Y_MIN;
    else              y = q[DATA_W-1:0];
    y_w     = {{EXT_W{y[DATA_W-1]}}, y};
    err_new = acc - (y_w <<< FRAC_W);
  end

endmodule

// File: rtl/dcb_state.sv
module dcb_state
  import dcb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 30,
  parameter int ACC_W  = 68
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     accept,
  input  logic                     flip_en,
  input  logic                     clip,
  input  logic signed [DATA_W-1:0] x_in,
  input  logic signed [DATA_W-1:0] y_new,
  input  logic signed [ACC_W-1:0]  err_new,
  output logic signed [DATA_W-1:0] x_prev,
  output logic signed [DATA_W-1:0] y_prev,
  output logic signed [ACC_W-1:0]  err_q,
  output fb_sign_e                 fb_sign
);

  localparam logic signed [ACC_W-1:0] ERR_ONE =
    {{(ACC_W-FRAC_W-1){1'b0}}, 1'b1, {FRAC_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_prev  <= '0;
      y_prev  <= '0;
      err_q   <= '0;
      fb_sign <= FB_ADD;
    end else if (accept) begin
      x_prev  <= x_in;
      y_prev  <= y_new;
      err_q   <= err_new;
      fb_sign <= (flip_en && clip) ? FB_SUB : FB_ADD;
    end
  end

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(x_prev) && $stable(y_prev) && $stable(err_q) && $stable(fb_sign)));

  // R3
  err_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !clip) |=> (err_q >= 0 && err_q < ERR_ONE));

  // R5
  fb_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !(flip_en && clip)) |=> (fb_sign == FB_ADD));

endmodule

// File: rtl/dc_blocker.sv
module dc_blocker
  import dcb_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int FRAC_W  = 30,
  parameter int GUARD_W = 4,
  parameter logic signed [DATA_W-1:0] ALPHA = 32'sd1073227115
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flip_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);

  localparam int ACC_W = 2 * DATA_W + GUARD_W;
  localparam logic [DATA_W-1:0] OUT_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] OUT_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic                     accept;
  logic signed [DATA_W-1:0] x_s, x_prev, y_prev, y_new;
  logic signed [ACC_W-1:0]  acc, err_q, err_new;
  logic                     clip_hi, clip_lo;
  fb_sign_e                 fb_sign;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign x_s      = in_data;

  dcb_accum #(
    .DATA_W (DATA_W),
    .FRAC_W (FRAC_W),
    .ACC_W  (ACC_W),
    .ALPHA  (ALPHA)
  ) u_accum (
    .x_in    (x_s),
    .x_prev  (x_prev),
    .y_prev  (y_prev),
    .err     (err_q),
    .fb_sign (fb_sign),
    .acc     (acc)
  );

  dcb_requant #(
    .DATA_W (DATA_W),
    .FRAC_W (FRAC_W),
    .ACC_W  (ACC_W)
  ) u_requant (
    .acc     (acc),
    .y       (y_new),
    .err_new (err_new),
    .clip_hi (clip_hi),
    .clip_lo (clip_lo)
  );

  dcb_state #(
    .DATA_W (DATA_W),
    .FRAC_W (FRAC_W),
    .ACC_W  (ACC_W)
  ) u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept),
    .flip_en (flip_en),
    .clip    (clip_hi || clip_lo),
    .x_in    (x_s),
    .y_new   (y_new),
    .err_new (err_new),
    .x_prev  (x_prev),
    .y_prev  (y_prev),
    .err_q   (err_q),
    .fb_sign (fb_sign)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= y_new;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R6
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R6
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R2
  state_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (y_prev == $signed(out_data)));

  // R4
  sat_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && clip_hi) |=> (out_data == OUT_MAX));

  // R4
  sat_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && clip_lo) |=> (out_data == OUT_MIN));

endmodule

// File: tb/test_dc_blocker.sv
module test_dc_blocker;

  localparam logic signed [31:0] ALPHA_TB = 32'sd1073227115;
  localparam logic signed [31:0] MAXV = 32'sh7FFFFFFF;
  localparam logic signed [31:0] MINV = 32'sh80000000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flip_en = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  // reference state
  logic signed [31:0] m_xp = '0;
  logic signed [31:0] m_yp = '0;
  logic signed [67:0] m_err = '0;
  bit                 m_neg = 1'b0;

  always #5 clk = ~clk;

  dc_blocker #(.ALPHA(ALPHA_TB)) i_dc_blocker (
    .clk       (clk),
    .rst_n     (rst_n),
    .flip_en   (flip_en),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    end
  endtask

  // Reference recurrence from R2..R5
  task automatic model_step(input logic signed [31:0] x, input bit flip, output logic signed [31:0] y);
    logic signed [67:0] xw, xpw, ypw, alw, a, q, yw;
    bit hi, lo;
    xw  = x;
    xpw = m_xp;
    ypw = m_yp;
    alw = ALPHA_TB;
    a   = ((xw - xpw) <<< 30) + ypw * alw + (m_neg ? -m_err : m_err);
    q   = a >>> 30;
    hi  = (q > 68'sd2147483647);
    lo  = (q < -68'sd2147483648);
    if (hi)      y = MAXV;
    else if (lo) y = MINV;
    else         y = q[31:0];
    yw    = y;
    m_err = a - (yw <<< 30);
    m_neg = flip && (hi || lo);
    m_xp  = x;
    m_yp  = y;
  endtask

  // Driver: present one sample, push the expected result when accepted
  task automatic send(input logic signed [31:0] x, input string tag);
    logic signed [31:0] y;
    @(posedge clk); #1;
    in_valid = 1'b1;
    in_data  = x;
    do @(negedge clk); while (!in_ready);
    model_step(x, flip_en, y);
    exp_q.push_back(y);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    in_valid = 1'b0;
    in_data  = 32'hDEAD_BEEF;
  endtask

  // Monitor: compare each transferred output with the scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6 unexpected output", out_data, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(out_data == e, t, out_data, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 32'h0, 32'h0);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(out_valid == 1'b0, "R1 out_valid after reset", {31'b0, out_valid}, 32'h0);
    check(in_ready == 1'b1, "R1 in_ready after reset", {31'b0, in_ready}, 32'h1);

    // R1 first sample passes unchanged
    send(32'sh1000_0000, "R1 first sample");

    // R2 mixed pattern
    for (int i = 1; i <= 20; i++) begin
      int v;
      v = ((i % 2) ? 1 : -1) * i * 50_000_000 + 123457;
      send(v, "R2 mixed pattern");
    end

    // R7 idle cycles with junk on the bus
    @(posedge clk); #1;
    in_data = 32'h7777_AAAA;
    repeat (6) @(posedge clk);
    send(32'sh0800_0000, "R7 after idle");

    // R6 back-pressure: output holds, input stalls, state untouched
    @(posedge clk); #1 out_ready = 1'b0;
    send(32'shF000_0001, "R6 stalled first");
    fork
      send(32'sh2222_2222, "R7 stalled second");
      begin
        @(negedge clk);
        held = out_data;
        repeat (3) begin
          @(negedge clk);
          check(out_valid && out_data == held, "R6 hold under back-pressure", out_data, held);
          check(in_ready == 1'b0, "R6 in_ready low when blocked", {31'b0, in_ready}, 32'h0);
        end
        @(posedge clk); #1 out_ready = 1'b1;
      end
    join

    // R4 full-scale steps, normal feedback
    flip_en = 1'b0;
    send(MAXV, "R4 step to max");
    send(MINV, "R4 step to min");
    for (int i = 0; i < 8; i++) send(MINV, "R4 hold at min");
    send(MAXV, "R4 step up again");
    for (int i = 0; i < 8; i++) send(MAXV, "R4 hold at max");

    // R5 sign reversal after clipping
    flip_en = 1'b1;
    send(MINV, "R5 step down flip");
    for (int i = 0; i < 6; i++) send(MINV, "R5 after clip");
    send(MAXV, "R5 step up flip");
    for (int i = 0; i < 6; i++) send(MAXV, "R5 after clip up");
    flip_en = 1'b0;

    // R3 long constant run stresses residue recycling
    for (int i = 0; i < 300; i++) send(32'sd357913941, "R3 constant run");
    for (int i = 0; i < 20; i++) send(32'sd5, "R3 tiny input");

    repeat (4) @(posedge clk);
    check(exp_q.size() == 0, "R6 all outputs delivered", exp_q.size(), 32'h0);
    summary();
    $finish;
  end

endmodule